// File: doc/BRIEF.md
# Character Display Host Bus Front End

This block sits between a host processor's parallel bus and the internal memories of a character display controller. The host drives a register-select line, a read/write line and an enable strobe, plus an 8-bit data bus. Every transfer takes effect on the falling edge of the enable strobe. Register-select low addresses the command path: a write there is a command, and a read returns status. Register-select high addresses the data register, which connects to the currently targeted display memory.

There are three memory banks: a 128-byte text memory, a 64-byte glyph memory and a 16-byte icon memory. An address-set command chooses the bank and loads a 7-bit address counter. A data write stores the byte in the targeted bank and advances the counter. Reads are served from a data register that is filled ahead of time. After an address-set command or a data read, the register holds the contents of the location the counter points to next. A busy flag covers a fixed number of clock cycles after each accepted command or data write.

The bus can run 8 bits wide. It can also run 4 bits wide, where each byte is carried on the upper four data lines as two strobes, high nibble first. A width-select command switches between the two widths.

Top module: `lcd_host_bus`

## Requirements
- R1: After reset the bus is 8 bits wide, the address counter is 0, the busy flag is 0, the text memory is targeted and the data register holds 0x00.
- R2: Bus lines are acted on only at the falling edge of the enable strobe, using the register-select, read/write and data values present at that edge. Values held while the strobe is high have no effect.
- R3: Command codes: 1aaaaaaa targets text memory at address aaaaaaa; 01aaaaaa targets glyph memory at address aaaaaa; 0001aaaa targets icon memory at address aaaa. In each case the counter is loaded with the zero-extended address.
- R4: A status read (register-select 0, read) returns the busy flag on bit 7 and the address counter on bits 6..0.
- R5: A data write (register-select 1, write) stores the byte at the counter's location in the targeted bank and increments the counter.
- R6: A data read (register-select 1, read) returns the data register. The register is then loaded from the targeted bank at the counter's location plus one, and the counter increments.
- R7: An address-set command loads the data register with the contents of the newly addressed location.
- R8: After a data write, the data register holds the byte just written.
- R9: An accepted command or data write holds the busy flag at 1 for BUSY_CYCLES clock cycles. Reads never set it.
- R10: A command or data write that completes while the busy flag is 1 is ignored. Counter, bank, bus width and memory are all left unchanged.
- R11: Command 001dxxxx sets the bus width: d=0 selects 4 bits and d=1 selects 8 bits.
- R12: In 4-bit mode every byte, including read data and status, is carried on data lines 7..4 over two strobes, high nibble first. An internal phase toggles on every strobe.
- R13: The counter wraps from 127 to 0. The glyph and icon banks use only the low 6 and low 4 counter bits respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Enable strobe; transfers take effect on its falling edge |
| bus_rs | input | 1 | Register select: 0 command/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_din | input | 8 | Write data from host (lines 7..4 only in 4-bit mode) |
| bus_dout | output | 8 | Read data to host (status or data register, nibble-aligned in 4-bit mode) |

## Verification
The falling strobe edge is registered once. The action it triggers lands on the next rising clock edge, so the counter, data register and busy flag change exactly one cycle after the falling edge is seen. The bench holds each strobe low for two further cycles before it starts the next access. The read bus is a combinational view of that state plus the current select line, so the bench samples it on a falling clock edge while the strobe is still high. The busy flag is due on the same edge as the accepted write and clears BUSY_CYCLES cycles later. The bench therefore probes it two cycles into the window and waits BUSY_CYCLES+2 cycles before any write that must be accepted.

// File: rtl/lhb_pkg.sv
package lhb_pkg;

    localparam int AC_W      = 7;
    localparam int NUM_BANKS = 3;

    typedef enum logic [1:0] {
        TGT_TEXT  = 2'd0,
        TGT_GLYPH = 2'd1,
        TGT_ICON  = 2'd2
    } tgt_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TEXT_ADDR,
        OP_GLYPH_ADDR,
        OP_ICON_ADDR,
        OP_WIDTH
    } op_e;

    typedef struct packed {
        logic       rs;
        logic       rw;
        logic [7:0] data;
    } xfer_t;

    function automatic op_e decode_cmd(input logic [7:0] c);
        if (c[7])                 return OP_TEXT_ADDR;
        else if (c[6])            return OP_GLYPH_ADDR;
        else if (c[5])            return OP_WIDTH;
        else if (c[4])            return OP_ICON_ADDR;
        else                      return OP_NONE;
    endfunction

    function automatic int bank_depth(input int idx);
        if (idx == 0)      return 128;
        else if (idx == 1) return 64;
        else               return 16;
    endfunction

endpackage

// File: rtl/lhb_bank.sv
module lhb_bank #(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lhb_sampler.sv
module lhb_sampler
    import lhb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       rs,
    input  logic       rw,
    input  logic [7:0] din,
    input  logic       dl,
    output logic       xfer_valid,
    output xfer_t      xfer,
    output logic       phase
);
    logic       en_q;
    logic [3:0] hi_nib;
    logic       fall;

    assign fall = en_q && !en;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            phase  <= 1'b0;
            hi_nib <= 4'h0;
        end else begin
            en_q <= en;
            if (dl) begin
                phase <= 1'b0;
            end else if (fall) begin
                phase <= ~phase;
                if (!phase) hi_nib <= din[7:4];
            end
        end
    end

    assign xfer_valid = fall && (dl || phase);
    assign xfer.rs    = rs;
    assign xfer.rw    = rw;
    assign xfer.data  = dl ? din : {hi_nib, din[7:4]};

    // R12
    nib_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && !dl) |=> (phase != $past(phase)));

    // R11
    wide_phase_chk: assert property (@(posedge clk) disable iff (rst)
        dl |-> !phase);
endmodule

// File: rtl/lhb_core.sv
module lhb_core
    import lhb_pkg::*;
#(
    parameter int BUSY_CYCLES = 37,
    localparam int BW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            xfer_valid,
    input  xfer_t           xfer,
    input  logic [7:0]      rd_data,
    output logic            dl,
    output logic            busy,
    output tgt_e            tgt,
    output tgt_e            rd_tgt,
    output logic [AC_W-1:0] ac,
    output logic [AC_W-1:0] rd_addr,
    output logic [7:0]      dr,
    output logic            we
);
    logic [BW-1:0] busy_cnt;
    op_e           op;
    logic          addr_set;

    assign busy = (busy_cnt != '0);
    assign op   = decode_cmd(xfer.data);
    assign addr_set = !xfer.rs &&
        (op == OP_TEXT_ADDR || op == OP_GLYPH_ADDR || op == OP_ICON_ADDR);
    assign we = xfer_valid && xfer.rs && !xfer.rw && !busy;

    always_comb begin
        rd_tgt  = tgt;
        rd_addr = ac + 1'b1;
        if (addr_set) begin
            case (op)
                OP_TEXT_ADDR:  begin rd_tgt = TGT_TEXT;  rd_addr = xfer.data[6:0]; end
                OP_GLYPH_ADDR: begin rd_tgt = TGT_GLYPH; rd_addr = {1'b0, xfer.data[5:0]}; end
                OP_ICON_ADDR:  begin rd_tgt = TGT_ICON;  rd_addr = {3'b000, xfer.data[3:0]}; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dl       <= 1'b1;
            tgt      <= TGT_TEXT;
            ac       <= '0;
            dr       <= 8'h00;
            busy_cnt <= '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (xfer_valid) begin
                if (!xfer.rw && !busy) begin
                    busy_cnt <= BW'(BUSY_CYCLES);
                    if (xfer.rs) begin
                        dr <= xfer.data;
                        ac <= ac + 1'b1;
                    end else if (addr_set) begin
                        tgt <= rd_tgt;
                        ac  <= rd_addr;
                        dr  <= rd_data;
                    end else if (op == OP_WIDTH) begin
                        dl <= xfer.data[4];
                    end
                end else if (xfer.rw && xfer.rs) begin
                    dr <= rd_data;
                    ac <= ac + 1'b1;
                end
            end
        end
    end

    // R2
    no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_valid |=> ($stable(ac) && $stable(dr) && $stable(tgt) && $stable(dl)));

    // R6
    ac_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer.rs && (xfer.rw || !busy)) |=> (ac == $past(ac) + 7'd1));

    // R9
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer.rw && !busy) |=> busy);

    // R10
    ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer.rw && busy) |=>
            ($stable(ac) && $stable(dl) && $stable(tgt) && $stable(dr)));
endmodule

// File: rtl/lcd_host_bus.sv
module lcd_host_bus
    import lhb_pkg::*;
#(
    parameter int BUSY_CYCLES = 37
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_en,
    input  logic       bus_rs,
    input  logic       bus_rw,
    input  logic [7:0] bus_din,
    output logic [7:0] bus_dout
);
    logic            xfer_valid;
    xfer_t           xfer;
    logic            phase;
    logic            dl;
    logic            busy;
    tgt_e            tgt;
    tgt_e            rd_tgt;
    logic [AC_W-1:0] ac;
    logic [AC_W-1:0] rd_addr;
    logic [7:0]      dr;
    logic            we;
    logic [7:0]      rd_data;
    logic [7:0]      bank_rd [NUM_BANKS];
    logic [7:0]      full_byte;

    lhb_sampler u_sampler (
        .clk        (clk),
        .rst        (rst),
        .en         (bus_en),
        .rs         (bus_rs),
        .rw         (bus_rw),
        .din        (bus_din),
        .dl         (dl),
        .xfer_valid (xfer_valid),
        .xfer       (xfer),
        .phase      (phase)
    );

    lhb_core #(.BUSY_CYCLES(BUSY_CYCLES)) u_core (
        .clk        (clk),
        .rst        (rst),
        .xfer_valid (xfer_valid),
        .xfer       (xfer),
        .rd_data    (rd_data),
        .dl         (dl),
        .busy       (busy),
        .tgt        (tgt),
        .rd_tgt     (rd_tgt),
        .ac         (ac),
        .rd_addr    (rd_addr),
        .dr         (dr),
        .we         (we)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int DEP = bank_depth(g);
        localparam int AW  = $clog2(DEP);
        lhb_bank #(.DEPTH(DEP)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (we && (tgt == tgt_e'(g))),
            .waddr (ac[AW-1:0]),
            .wdata (xfer.data),
            .raddr (rd_addr[AW-1:0]),
            .rdata (bank_rd[g])
        );
    end

    always_comb begin
        case (rd_tgt)
            TGT_GLYPH: rd_data = bank_rd[1];
            TGT_ICON:  rd_data = bank_rd[2];
            default:   rd_data = bank_rd[0];
        endcase
    end

    assign full_byte = bus_rs ? dr : {busy, ac};
    assign bus_dout  = dl    ? full_byte :
                       phase ? {full_byte[3:0], 4'h0} : {full_byte[7:4], 4'h0};
endmodule

// File: tb/lcd_host_bus_tb.sv
module lcd_host_bus_tb_top;
    localparam int BUSY = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0;
    logic       bus_rs = 1'b0;
    logic       bus_rw = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lcd_host_bus #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_rs(bus_rs),
        .bus_rw(bus_rw), .bus_din(bus_din), .bus_dout(bus_dout)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic strobe(input logic rs, input logic rw, input logic [7:0] d,
                          output logic [7:0] rd);
        @(negedge clk);
        bus_rs = rs; bus_rw = rw; bus_din = d; bus_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd = bus_dout;
        bus_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        repeat (BUSY + 2) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] c);
        logic [7:0] x;
        strobe(1'b0, 1'b0, c, x);
        idle();
    endtask

    task automatic wdat(input logic [7:0] d);
        logic [7:0] x;
        strobe(1'b1, 1'b0, d, x);
        idle();
    endtask

    task automatic status(output logic [7:0] s);
        strobe(1'b0, 1'b1, 8'h00, s);
    endtask

    task automatic rdat(output logic [7:0] d);
        strobe(1'b1, 1'b1, 8'h00, d);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] v;
        logic [7:0] w;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        status(v); chk("R1 status", v, 8'h00);
        rdat(v);   chk("R1 data register", v, 8'h00);
        // R6 counter advanced by the read
        status(v); chk("R6 ac after read", v, 8'h01);

        // R2 values held while strobe high have no effect
        @(negedge clk);
        bus_rs = 1'b1; bus_rw = 1'b0; bus_din = 8'hEE; bus_en = 1'b1;
        repeat (3) @(negedge clk);
        bus_rs = 1'b0; bus_rw = 1'b1;
        @(negedge clk);
        chk("R2 status during strobe", bus_dout, 8'h01);
        bus_en = 1'b0;
        repeat (BUSY + 2) @(negedge clk);
        status(v); chk("R2 no write at fall", v, 8'h01);

        // R5 R13 sweep full text memory
        cmd(8'h80);
        for (int i = 0; i < 128; i++) wdat(pat(i));
        status(v); chk("R13 ac wrapped after writes", v, 8'h00);
        // R8 data register holds last written byte
        rdat(v); chk("R8 dr after write", v, pat(127));

        // R7 R6 prefetched reads of all locations
        cmd(8'h80);
        for (int i = 0; i < 128; i++) begin
            rdat(v); chk("R6 sweep read", v, pat(i));
        end
        status(v); chk("R13 ac wrapped after reads", v, 8'h00);

        // R3 R4 R9 text address set, busy in status
        strobe(1'b0, 1'b0, 8'hA5, w);
        status(v); chk("R9 busy after command", v, 8'hA5);
        idle();
        status(v); chk("R4 status idle", v, 8'h25);
        rdat(v); chk("R7 prefetch text", v, pat(8'h25));
        status(v); chk("R9 read leaves busy clear", v, 8'h26);

        // R3 R5 glyph bank
        cmd(8'h45);
        status(v); chk("R3 glyph address", v, 8'h05);
        wdat(8'hA5);
        status(v); chk("R5 ac increments", v, 8'h06);
        cmd(8'h45);
        rdat(v); chk("R5 glyph readback", v, 8'hA5);
        // R13 glyph aliasing past 63
        cmd(8'h7F);
        wdat(8'h99);
        wdat(8'h77);
        cmd(8'h40);
        rdat(v); chk("R13 glyph alias", v, 8'h77);

        // R3 icon bank and bank isolation
        cmd(8'h13);
        status(v); chk("R3 icon address", v, 8'h03);
        wdat(8'h5C);
        cmd(8'h13);
        rdat(v); chk("R5 icon readback", v, 8'h5C);
        cmd(8'h83);
        rdat(v); chk("R5 text untouched", v, pat(3));

        // R10 write while busy is ignored
        cmd(8'h90);
        strobe(1'b1, 1'b0, 8'h11, w);
        strobe(1'b1, 1'b0, 8'h22, w);
        idle();
        status(v); chk("R10 ac single step", v, 8'h11);
        cmd(8'h90);
        rdat(v); chk("R10 first write kept", v, 8'h11);
        rdat(v); chk("R10 ignored write absent", v, pat(8'h11));

        // R11 R12 four-bit mode
        cmd(8'h20);
        strobe(1'b0, 1'b0, 8'h80, w);
        strobe(1'b0, 1'b0, 8'hA0, w);
        idle();
        status(v); chk("R12 status high nibble", v, 8'h00);
        status(v); chk("R12 status low nibble", v, 8'hA0);
        strobe(1'b1, 1'b0, 8'h30, w);
        strobe(1'b1, 1'b0, 8'hC0, w);
        idle();
        status(v); chk("R12 ac high nibble", v, 8'h00);
        status(v); chk("R12 ac low nibble", v, 8'hB0);
        strobe(1'b0, 1'b0, 8'h80, w);
        strobe(1'b0, 1'b0, 8'hA0, w);
        idle();
        rdat(v); chk("R12 data high nibble", v, 8'h30);
        rdat(v); chk("R12 data low nibble", v, 8'hC0);
        strobe(1'b0, 1'b0, 8'h30, w);
        strobe(1'b0, 1'b0, 8'h00, w);
        idle();
        status(v); chk("R11 back to 8-bit", v, 8'h0B);
        rdat(v); chk("R11 8-bit data read", v, pat(8'h0B));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule